// File: doc/BRIEF.md
# Operand Bypass Selection Unit

This block picks the source of each operand consumed late in a five-stage pipeline. For the instruction now in execute it compares the two source register numbers against the destinations of the two older instructions still in flight, one in the memory stage and one in write-back. It returns a two-bit select code for each execute-stage ALU operand. A third code steers the store data of a store sitting in the memory stage, so a value loaded by the instruction just ahead of it can be stored without a stall.

The unit is pure combinational logic with no clock, no reset and no state. Its selects follow its inputs within the same cycle. The datapath multiplexers and the load-use stall logic sit outside it; this block only drives their select lines. The style's valid/ready stream rules do not apply: every pin is a plain control signal.

Select encoding, shared by all three outputs: 2'b00 register-file value, 2'b01 memory-stage ALU result, 2'b10 write-back result. Code 2'b11 is never produced.

Top module: `operand_bypass_unit`

## Requirements
- R1: An ALU operand select is 2'b01 when the memory-stage producer is valid, has its register-write flag set, is not a load, and its destination equals that operand's nonzero source register.
- R2: An ALU operand select is 2'b10 when the write-back producer is valid, has its register-write flag set and its destination equals the nonzero source register, and the memory stage does not match that register.
- R3: When both producers match the same source register, the memory stage (the younger producer) decides the select; write-back is not chosen.
- R4: A source register number of 0 always gives select 2'b00, even if a producer writes register 0.
- R5: A producer whose valid bit is clear, or whose register-write flag is clear, never causes a forward.
- R6: A matching memory-stage load gives select 2'b00 for that operand and hides any write-back match; the stall logic resolves that case.
- R7: The store-data select is 2'b10 when the write-back producer is valid, writes, and its destination equals the nonzero store rt. Otherwise it is 2'b00. It is never 2'b01, and the memory-stage fields do not affect it.
- R8: Operands A (from rs) and B (from rt) are selected independently. Two operands naming the same register receive the same select.
- R9: The outputs depend only on the present inputs. A change of inputs is reflected without any clock edge, and the same inputs always give the same outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_i | input | REG_AW | Execute-stage first source register |
| ex_rt_i | input | REG_AW | Execute-stage second source register |
| mem_dest_i | input | REG_AW | Memory-stage destination register |
| mem_wr_i | input | 1 | Memory-stage register-write flag |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| mem_vld_i | input | 1 | Memory-stage slot holds a valid instruction |
| wb_dest_i | input | REG_AW | Write-back destination register |
| wb_wr_i | input | 1 | Write-back register-write flag |
| wb_vld_i | input | 1 | Write-back slot holds a valid instruction |
| st_rt_i | input | REG_AW | Data register of the store in the memory stage |
| sel_a_o | output | 2 | Select for ALU operand A |
| sel_b_o | output | 2 | Select for ALU operand B |
| sel_st_o | output | 2 | Select for store data |

## Verification
The bench targets the cases where the two producers compete. When both producers match, a design that reverses the priority feeds the ALU a stale write-back value. When a load in the memory stage matches, a wrong design forwards an address instead of the data, or falls through to an older value. Writes to register 0, and producers that are invalid or do not write, are driven with matching register numbers. A design that skips those qualifiers then returns a nonzero select. The load-then-store case is also driven, with memory-stage fields set to match, so that store data taken from the wrong stage shows up as a wrong code.

// File: rtl/byp_pkg.sv
package byp_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF  = 2'b00,
    SEL_MEM = 2'b01,
    SEL_WB  = 2'b10
  } byp_sel_e;
endpackage

// File: rtl/byp_producer_hit.sv
module byp_producer_hit #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] dest_i,
  input  logic              wr_i,
  input  logic              vld_i,
  output logic              hit_o
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  always_comb begin
    hit_o = vld_i && wr_i && (src_i != ZERO_REG) && (dest_i == src_i);
  end
endmodule

// File: rtl/byp_operand_sel.sv
module byp_operand_sel
  import byp_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] mem_dest_i,
  input  logic              mem_wr_i,
  input  logic              mem_load_i,
  input  logic              mem_vld_i,
  input  logic [REG_AW-1:0] wb_dest_i,
  input  logic              wb_wr_i,
  input  logic              wb_vld_i,
  output logic [SEL_W-1:0]  sel_o
);
  logic mem_hit;
  logic wb_hit;

  byp_producer_hit #(.REG_AW(REG_AW)) mem_cmp_i (
    .src_i (src_i),
    .dest_i(mem_dest_i),
    .wr_i  (mem_wr_i),
    .vld_i (mem_vld_i),
    .hit_o (mem_hit)
  );

  byp_producer_hit #(.REG_AW(REG_AW)) wb_cmp_i (
    .src_i (src_i),
    .dest_i(wb_dest_i),
    .wr_i  (wb_wr_i),
    .vld_i (wb_vld_i),
    .hit_o (wb_hit)
  );

  // Younger producer first; a load there leaves the register-file path
  // selected because its data does not exist yet.
  always_comb begin
    if (mem_hit) begin
      sel_o = mem_load_i ? SEL_RF : SEL_MEM;
    end else if (wb_hit) begin
      sel_o = SEL_WB;
    end else begin
      sel_o = SEL_RF;
    end
  end
endmodule

// File: rtl/byp_store_sel.sv
module byp_store_sel
  import byp_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] st_rt_i,
  input  logic [REG_AW-1:0] wb_dest_i,
  input  logic              wb_wr_i,
  input  logic              wb_vld_i,
  output logic [SEL_W-1:0]  sel_o
);
  logic wb_hit;

  byp_producer_hit #(.REG_AW(REG_AW)) st_cmp_i (
    .src_i (st_rt_i),
    .dest_i(wb_dest_i),
    .wr_i  (wb_wr_i),
    .vld_i (wb_vld_i),
    .hit_o (wb_hit)
  );

  always_comb begin
    sel_o = wb_hit ? SEL_WB : SEL_RF;
  end
endmodule

// File: rtl/operand_bypass_unit.sv
module operand_bypass_unit
  import byp_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] ex_rs_i,
  input  logic [REG_AW-1:0] ex_rt_i,
  input  logic [REG_AW-1:0] mem_dest_i,
  input  logic              mem_wr_i,
  input  logic              mem_load_i,
  input  logic              mem_vld_i,
  input  logic [REG_AW-1:0] wb_dest_i,
  input  logic              wb_wr_i,
  input  logic              wb_vld_i,
  input  logic [REG_AW-1:0] st_rt_i,
  output logic [1:0]        sel_a_o,
  output logic [1:0]        sel_b_o,
  output logic [1:0]        sel_st_o
);
  localparam int unsigned NUM_ALU_SRC = 2;

  logic [REG_AW-1:0] alu_src [NUM_ALU_SRC];
  logic [SEL_W-1:0]  alu_sel [NUM_ALU_SRC];

  assign alu_src[0] = ex_rs_i;
  assign alu_src[1] = ex_rt_i;

  for (genvar g = 0; g < NUM_ALU_SRC; g++) begin : g_alu_src
    byp_operand_sel #(.REG_AW(REG_AW)) opsel_i (
      .src_i     (alu_src[g]),
      .mem_dest_i(mem_dest_i),
      .mem_wr_i  (mem_wr_i),
      .mem_load_i(mem_load_i),
      .mem_vld_i (mem_vld_i),
      .wb_dest_i (wb_dest_i),
      .wb_wr_i   (wb_wr_i),
      .wb_vld_i  (wb_vld_i),
      .sel_o     (alu_sel[g])
    );
  end

  byp_store_sel #(.REG_AW(REG_AW)) stsel_i (
    .st_rt_i  (st_rt_i),
    .wb_dest_i(wb_dest_i),
    .wb_wr_i  (wb_wr_i),
    .wb_vld_i (wb_vld_i),
    .sel_o    (sel_st_o)
  );

  assign sel_a_o = alu_sel[0];
  assign sel_b_o = alu_sel[1];
endmodule

// File: rtl/operand_bypass_checker.sv
module operand_bypass_checker #(
  parameter int unsigned REG_AW = 5
) (
  input logic [REG_AW-1:0] ex_rs_i,
  input logic [REG_AW-1:0] ex_rt_i,
  input logic [REG_AW-1:0] mem_dest_i,
  input logic              mem_wr_i,
  input logic              mem_load_i,
  input logic              mem_vld_i,
  input logic [REG_AW-1:0] wb_dest_i,
  input logic              wb_wr_i,
  input logic              wb_vld_i,
  input logic [REG_AW-1:0] st_rt_i,
  input logic [1:0]        sel_a_o,
  input logic [1:0]        sel_b_o,
  input logic [1:0]        sel_st_o
);
  always_comb begin
    if (ex_rs_i == '0) begin
      assert_zero_reg_R4: assert (sel_a_o == 2'b00)
        else $error("sel_a nonzero for register 0");
    end
    if (mem_vld_i && mem_wr_i && !mem_load_i && ex_rs_i != '0 && mem_dest_i == ex_rs_i) begin
      assert_mem_wins_R3: assert (sel_a_o == 2'b01)
        else $error("memory-stage producer did not win");
    end
    if (!mem_vld_i && !wb_vld_i) begin
      assert_no_producer_R5: assert (sel_a_o == 2'b00 && sel_b_o == 2'b00 && sel_st_o == 2'b00)
        else $error("forward with no valid producer");
    end
    if (mem_vld_i && mem_wr_i && mem_load_i && ex_rt_i != '0 && mem_dest_i == ex_rt_i) begin
      assert_load_hold_R6: assert (sel_b_o == 2'b00)
        else $error("forward around a memory-stage load");
    end
    assert_store_code_R7: assert (sel_st_o != 2'b01)
      else $error("store select took memory-stage code");
    if (ex_rs_i == ex_rt_i) begin
      assert_same_src_R8: assert (sel_a_o == sel_b_o)
        else $error("same source, different selects");
    end
  end
endmodule

bind operand_bypass_unit operand_bypass_checker #(.REG_AW(REG_AW)) chk_i (
  .ex_rs_i   (ex_rs_i),
  .ex_rt_i   (ex_rt_i),
  .mem_dest_i(mem_dest_i),
  .mem_wr_i  (mem_wr_i),
  .mem_load_i(mem_load_i),
  .mem_vld_i (mem_vld_i),
  .wb_dest_i (wb_dest_i),
  .wb_wr_i   (wb_wr_i),
  .wb_vld_i  (wb_vld_i),
  .st_rt_i   (st_rt_i),
  .sel_a_o   (sel_a_o),
  .sel_b_o   (sel_b_o),
  .sel_st_o  (sel_st_o)
);

// File: tb/operand_bypass_unit_tb_top.sv
module operand_bypass_unit_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] ex_rs, ex_rt, mem_dest, wb_dest, st_rt;
  logic mem_wr, mem_load, mem_vld, wb_wr, wb_vld;
  logic [1:0] sel_a, sel_b, sel_st;

  operand_bypass_unit #(.REG_AW(AW)) dut_i (
    .ex_rs_i(ex_rs), .ex_rt_i(ex_rt),
    .mem_dest_i(mem_dest), .mem_wr_i(mem_wr), .mem_load_i(mem_load), .mem_vld_i(mem_vld),
    .wb_dest_i(wb_dest), .wb_wr_i(wb_wr), .wb_vld_i(wb_vld),
    .st_rt_i(st_rt),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .sel_st_o(sel_st)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0] exp_q [$];
  string      tag_q [$];

  // Expected codes derived from the requirement text.
  function automatic logic [1:0] want_alu(input logic [AW-1:0] s);
    if (s == '0) return 2'b00;                                   // R4
    if (mem_vld && mem_wr && mem_dest == s) begin
      if (mem_load) return 2'b00;                                // R6
      return 2'b01;                                              // R1, R3
    end
    if (wb_vld && wb_wr && wb_dest == s) return 2'b10;           // R2
    return 2'b00;                                                // R5
  endfunction

  function automatic logic [1:0] want_st();
    if (st_rt == '0) return 2'b00;
    if (wb_vld && wb_wr && wb_dest == st_rt) return 2'b10;       // R7
    return 2'b00;
  endfunction

  task automatic drive(input logic [AW-1:0] rs, input logic [AW-1:0] rt,
                       input logic [AW-1:0] md, input logic mw, input logic ml, input logic mv,
                       input logic [AW-1:0] wd, input logic ww, input logic wv,
                       input logic [AW-1:0] srt, input string tag);
    @(posedge clk);
    ex_rs = rs; ex_rt = rt;
    mem_dest = md; mem_wr = mw; mem_load = ml; mem_vld = mv;
    wb_dest = wd; wb_wr = ww; wb_vld = wv; st_rt = srt;
    exp_q.push_back({want_alu(rs), want_alu(rt), want_st()});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      logic [5:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({sel_a, sel_b, sel_st} != e) begin
        errors++;
        $display("FAIL %s: got a=%b b=%b st=%b expected a=%b b=%b st=%b",
                 t, sel_a, sel_b, sel_st, e[5:4], e[3:2], e[1:0]);
      end
    end
  end

  initial begin
    ex_rs = '0; ex_rt = '0; mem_dest = '0; wb_dest = '0; st_rt = '0;
    mem_wr = 0; mem_load = 0; mem_vld = 0; wb_wr = 0; wb_vld = 0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // reset state: quiet pipeline
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5 idle");
    drive(3, 4, 3, 1, 0, 1, 9, 1, 1, 9, "R1 mem to A, wb to store");
    drive(6, 7, 1, 1, 0, 1, 7, 1, 1, 2, "R2 wb to B");
    drive(5, 5, 5, 1, 0, 1, 5, 1, 1, 5, "R3 both match, R8 same src");
    drive(8, 2, 2, 1, 0, 1, 8, 1, 1, 8, "R3 split A wb B mem, R8");
    drive(0, 0, 0, 1, 0, 1, 0, 1, 1, 0, "R4 register zero");
    drive(4, 4, 4, 1, 0, 0, 4, 1, 0, 4, "R5 both invalid");
    drive(4, 4, 4, 0, 0, 1, 4, 0, 1, 4, "R5 no write flag");
    drive(11, 12, 11, 1, 1, 1, 11, 1, 1, 11, "R6 mem load hides wb");
    drive(12, 11, 11, 1, 1, 1, 11, 1, 1, 3, "R6 load match on B");
    drive(1, 2, 13, 1, 1, 1, 13, 1, 1, 13, "R7 load to store");
    drive(1, 2, 14, 1, 0, 1, 15, 1, 1, 14, "R7 store ignores mem stage");
    drive(31, 30, 31, 1, 0, 1, 30, 1, 1, 30, "R1 R2 top registers");
    // R9: inputs change mid-cycle with no clock edge, outputs follow
    @(posedge clk);
    #(CLK_PERIOD/4);
    ex_rs = 9; mem_dest = 9; mem_wr = 1; mem_load = 0; mem_vld = 1;
    #1;
    checks++;
    if (sel_a != 2'b01) begin
      errors++;
      $display("FAIL R9 comb follow: got %b expected 01", sel_a);
    end
    mem_vld = 0;
    #1;
    checks++;
    if (sel_a != 2'b00) begin
      errors++;
      $display("FAIL R9 comb release: got %b expected 00", sel_a);
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule